// File: doc/BRIEF.md
# Tuning-Loop Divider and Three-State Phase Comparator

This block is the digital heart of a frequency-synthesizer tuning loop. A crystal-rate tick stream (nominally 75 kHz) is divided down to one of seven reference rates. The local-oscillator signal arrives as a digitized tick stream on one of two pins. The FM pin goes through a dual-modulus 16/17 prescaler with a swallow counter. The AM pin feeds the programmable counter directly. In both cases the oscillator is divided by a loaded ratio N. A phase/frequency comparator then weighs the two divided edge streams. Its error output is modelled as a drive-enable and a drive-value pair, so that the floating state can be observed.

All logic runs on one system clock. The crystal and oscillator events enter as single-cycle enables. Software writes N, the reference code and the band code in a single strobe. A new N or reference code takes hold only when the matching counter reaches its terminal count. Three low-power inputs stop the loop and float the output: halt, backup and loop-stop. A sticky unlock flag records any error pulse that outlives a programmable number of crystal ticks, and a read strobe clears it.

Top module: `tune_pll_core`

## Requirements
- R1: After reset the error output floats (eo_oe = 0), unlock_flag is 0, and the band code is 00.
- R2: The reference code picks the crystal divisor: 0→75, 1→25, 2→24, 3→15, 4→12, 5→6, 6→3, and 7→75. The first crystal tick after reset or re-enable produces a reference edge. Each following reference edge comes after exactly that many crystal ticks.
- R3: When cfg_band[1] = 1, the AM tick input is divided directly by N (N ≥ 2). am_bw_low is 1 only for band code 11.
- R4: When cfg_band[1] = 0, the FM tick input is divided by N = 16·M + S, where M = N[NW-1:4] and S = N[3:0]. This holds for M ≥ 1 and S ≤ M. cfg_band[0] has no effect in this case. The input of the band that is not selected is ignored.
- R5: A divided-oscillator edge arriving first drives the output high (eo_oe = 1, eo_val = 1). A reference edge arriving first drives it low (eo_oe = 1, eo_val = 0). The output floats once the other edge arrives. Edges that coincide leave it floating. The drive level never changes without passing through the floating state.
- R6: A ratio written mid-count does not change the period in progress. It applies from the next terminal count.
- R7: While halt_i, backup_i or stop_i is high, the output floats from the next cycle and all ticks are ignored. After release, both dividers restart, so the first crystal tick produces a reference edge (R2).
- R8: unlock_flag sets on the (lock_lim+1)-th crystal tick seen during one continuous driven interval of the output.
- R9: unlock_flag holds until unlock_clr is sampled high. If a set condition falls in the same cycle as unlock_clr, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtal_tick | input | 1 | One-cycle crystal event |
| fm_tick | input | 1 | One-cycle FM oscillator event |
| am_tick | input | 1 | One-cycle AM oscillator event |
| halt_i | input | 1 | Halt mode, loop disabled |
| backup_i | input | 1 | Backup mode, loop disabled |
| stop_i | input | 1 | Loop-stop mode, loop disabled |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_n | input | NW | Division ratio N |
| cfg_ref | input | 3 | Reference rate code |
| cfg_band | input | 2 | Band code: bit 1 = AM pin, bit 0 = narrow AM band |
| lock_lim | input | LW | Error-length limit in crystal ticks |
| unlock_clr | input | 1 | Read-and-clear strobe for the unlock flag |
| unlock_flag | output | 1 | Sticky loss-of-lock flag |
| eo_oe | output | 1 | Error output drive enable (0 = floating) |
| eo_val | output | 1 | Error output drive level |
| am_bw_low | output | 1 | Selects the narrow AM amplifier band |

## Verification
The unlock flag can be set and read-cleared in the same cycle. The bench holds a divided-oscillator error active past the limit, so every further crystal tick sets the flag again. It then raises unlock_clr together with a crystal tick and expects the flag to stay 1. A clear strobe with no tick must drop the flag to 0. The second collision is a reference edge landing on the same cycle as a divided-oscillator edge. Right after reset, both ticks are driven together and the output must stay floating.

// File: rtl/tune_pll_core.sv
module tune_pll_core #(
  parameter int NW = 16,
  parameter int LW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          xtal_tick,
  input  logic          fm_tick,
  input  logic          am_tick,
  input  logic          halt_i,
  input  logic          backup_i,
  input  logic          stop_i,
  input  logic          cfg_we,
  input  logic [NW-1:0] cfg_n,
  input  logic [2:0]    cfg_ref,
  input  logic [1:0]    cfg_band,
  input  logic [LW-1:0] lock_lim,
  input  logic          unlock_clr,
  output logic          unlock_flag,
  output logic          eo_oe,
  output logic          eo_val,
  output logic          am_bw_low
);
  localparam int MW = NW - 4;
  localparam int RW = 7;

  logic [NW-1:0] n_hold, prog_cnt;
  logic [2:0]    ref_hold;
  logic [1:0]    band;
  logic [RW-1:0] ref_cnt;
  logic [4:0]    pre_cnt;
  logic [3:0]    swal_cnt;
  logic          up, dn;
  logic [LW-1:0] err_len;

  function automatic logic [RW-1:0] ref_div(input logic [2:0] code);
    case (code)
      3'd1:    return 7'd25;
      3'd2:    return 7'd24;
      3'd3:    return 7'd15;
      3'd4:    return 7'd12;
      3'd5:    return 7'd6;
      3'd6:    return 7'd3;
      default: return 7'd75;
    endcase
  endfunction

  wire           off      = halt_i | backup_i | stop_i;
  wire           fm_mode  = ~band[1];
  wire           osc_tick = (fm_mode ? fm_tick : am_tick) & ~off;
  wire           pre_end  = (pre_cnt == '0);
  wire           ref_p    = xtal_tick & ~off & (ref_cnt == '0);
  wire           fdiv_p   = osc_tick & (prog_cnt == '0) & (~fm_mode | pre_end);
  wire [3:0]     swal_dec = (swal_cnt != 4'd0) ? swal_cnt - 4'd1 : 4'd0;
  wire [MW-1:0]  m_new    = n_hold[NW-1:4];
  wire [3:0]     s_new    = n_hold[3:0];
  wire [NW-1:0]  m_ext    = {{4{1'b0}}, m_new};
  wire           up_n     = up | fdiv_p;
  wire           dn_n     = dn | ref_p;
  wire           act      = up | dn;
  wire           flag_set = act & xtal_tick & ~off & (err_len >= lock_lim);

  assign eo_oe     = act;
  assign eo_val    = up;
  assign am_bw_low = (band == 2'b11);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      n_hold   <= NW'(256);
      ref_hold <= 3'd0;
      band     <= 2'b00;
    end else if (cfg_we) begin
      n_hold   <= cfg_n;
      ref_hold <= cfg_ref;
      band     <= cfg_band;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          ref_cnt <= '0;
    else if (off)        ref_cnt <= '0;
    else if (xtal_tick)  ref_cnt <= ref_p ? ref_div(ref_hold) - 7'd1 : ref_cnt - 7'd1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      prog_cnt <= '0;
      pre_cnt  <= '0;
      swal_cnt <= '0;
    end else if (off) begin
      prog_cnt <= '0;
      pre_cnt  <= '0;
      swal_cnt <= '0;
    end else if (osc_tick) begin
      if (fdiv_p) begin
        prog_cnt <= fm_mode ? m_ext - 1'b1 : n_hold - 1'b1;
        swal_cnt <= s_new;
        pre_cnt  <= (s_new != 4'd0) ? 5'd16 : 5'd15;
      end else if (fm_mode && !pre_end) begin
        pre_cnt  <= pre_cnt - 5'd1;
      end else begin
        prog_cnt <= prog_cnt - 1'b1;
        if (fm_mode) begin
          swal_cnt <= swal_dec;
          pre_cnt  <= (swal_dec != 4'd0) ? 5'd16 : 5'd15;
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else if (off) begin
      up <= 1'b0;
      dn <= 1'b0;
    end else begin
      up <= up_n & ~dn_n;
      dn <= dn_n & ~up_n;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      err_len     <= '0;
      unlock_flag <= 1'b0;
    end else begin
      if (!act || off)                         err_len <= '0;
      else if (xtal_tick && err_len < lock_lim) err_len <= err_len + 1'b1;
      unlock_flag <= flag_set | (unlock_flag & ~unlock_clr);
    end
endmodule

module tune_pll_core_chk (
  input logic clk,
  input logic rst_n,
  input logic xtal_tick,
  input logic fm_tick,
  input logic am_tick,
  input logic halt_i,
  input logic backup_i,
  input logic stop_i,
  input logic unlock_clr,
  input logic unlock_flag,
  input logic eo_oe,
  input logic eo_val
);
  a_r7_off_floats: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_i || backup_i || stop_i) |=> !eo_oe);

  a_r5_tick_starts: assert property (@(posedge clk) disable iff (!rst_n)
    (!xtal_tick && !fm_tick && !am_tick && !eo_oe) |=> !eo_oe);

  a_r5_no_flip_hi: assert property (@(posedge clk) disable iff (!rst_n)
    (eo_oe && eo_val) |=> (!eo_oe || eo_val));

  a_r5_no_flip_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (eo_oe && !eo_val) |=> (!eo_oe || !eo_val));

  a_r8_set_needs_error: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlock_flag) |-> ($past(eo_oe) && $past(xtal_tick)));

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (unlock_flag && !unlock_clr) |=> unlock_flag);
endmodule

bind tune_pll_core tune_pll_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .fm_tick(fm_tick),
  .am_tick(am_tick), .halt_i(halt_i), .backup_i(backup_i), .stop_i(stop_i),
  .unlock_clr(unlock_clr), .unlock_flag(unlock_flag), .eo_oe(eo_oe),
  .eo_val(eo_val)
);

// File: tb/test_tune_pll_core.sv
`timescale 1ns/1ps
module test_tune_pll_core;
  localparam int NW = 16;
  localparam int LW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xtal_tick = 0, fm_tick = 0, am_tick = 0;
  logic halt_i = 0, backup_i = 0, stop_i = 0;
  logic cfg_we = 0;
  logic [NW-1:0] cfg_n = '0;
  logic [2:0] cfg_ref = '0;
  logic [1:0] cfg_band = '0;
  logic [LW-1:0] lock_lim = 8'd255;
  logic unlock_clr = 0;
  logic unlock_flag, eo_oe, eo_val, am_bw_low;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tune_pll_core #(.NW(NW), .LW(LW)) i_tune_pll_core (
    .clk(clk), .rst_n(rst_n), .xtal_tick(xtal_tick), .fm_tick(fm_tick),
    .am_tick(am_tick), .halt_i(halt_i), .backup_i(backup_i), .stop_i(stop_i),
    .cfg_we(cfg_we), .cfg_n(cfg_n), .cfg_ref(cfg_ref), .cfg_band(cfg_band),
    .lock_lim(lock_lim), .unlock_clr(unlock_clr), .unlock_flag(unlock_flag),
    .eo_oe(eo_oe), .eo_val(eo_val), .am_bw_low(am_bw_low)
  );

  // {band[1:0], ref code[2:0], N[15:0], expected divisor[6:0]}
  localparam logic [27:0] VEC [8] = '{
    {2'b10, 3'd0, 16'd37,   7'd75},
    {2'b11, 3'd1, 16'd2,    7'd25},
    {2'b00, 3'd2, 16'd300,  7'd24},
    {2'b00, 3'd3, 16'd259,  7'd15},
    {2'b10, 3'd4, 16'd1000, 7'd12},
    {2'b11, 3'd5, 16'd5,    7'd6},
    {2'b01, 3'd6, 16'd16,   7'd3},
    {2'b10, 3'd7, 16'd3,    7'd75}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic x, input logic f, input logic a);
    xtal_tick = x; fm_tick = f; am_tick = a;
    @(negedge clk);
    xtal_tick = 0; fm_tick = 0; am_tick = 0;
  endtask

  task automatic osc(input logic [1:0] b, input logic other);
    if (b[1]) step(1'b0, other, 1'b1);
    else      step(1'b0, 1'b1, other);
  endtask

  task automatic do_reset();
    rst_n = 0; halt_i = 0; backup_i = 0; stop_i = 0; unlock_clr = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic cfg(input logic [1:0] b, input logic [2:0] r, input logic [NW-1:0] n);
    cfg_band = b; cfg_ref = r; cfg_n = n; cfg_we = 1;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic sync_loop(input logic [1:0] b);
    step(1, 0, 0);
    osc(b, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int k;
    logic [27:0] v;
    @(negedge clk);
    do_reset();
    chk("R1 eo_oe after reset", eo_oe, 0);
    chk("R1 unlock_flag after reset", unlock_flag, 0);
    chk("R1 am_bw_low after reset", am_bw_low, 0);

    for (int i = 0; i < 8; i++) begin
      v = VEC[i];
      do_reset();
      cfg(v[27:26], v[25:23], v[22:7]);
      chk("R3 am_bw_low for band code", am_bw_low, (v[27:26] == 2'b11) ? 1 : 0);
      step(1, 0, 0);
      chk("R2 first crystal tick drives low, oe", eo_oe, 1);
      chk("R5 reference first drives low, val", eo_val, 0);
      osc(v[27:26], 1'b0);
      chk("R5 float after divided edge", eo_oe, 0);
      k = 0;
      do begin step(1, 0, 0); k++; end while (!eo_oe && k < 200);
      chk("R2 reference divisor", k, int'(v[6:0]));
      k = 0;
      do begin osc(v[27:26], 1'b1); k++; end while (eo_oe && k < 2000);
      chk(v[27] ? "R3 AM division ratio" : "R4 FM dual-modulus ratio", k, int'(v[22:7]));
    end

    do_reset();
    cfg(2'b10, 3'd0, 16'd5);
    step(1, 0, 1);
    chk("R5 coinciding edges leave output floating", eo_oe, 0);

    do_reset();
    cfg(2'b10, 3'd0, 16'd10);
    sync_loop(2'b10);
    repeat (4) osc(2'b10, 1'b0);
    cfg(2'b10, 3'd0, 16'd20);
    k = 4;
    do begin osc(2'b10, 1'b0); k++; end while (!eo_oe && k < 100);
    chk("R6 period in progress keeps old N", k, 10);
    chk("R6 divided edge first drives high", eo_val, 1);
    repeat (75) step(1, 0, 0);
    chk("R5 reference edge floats high drive", eo_oe, 0);
    k = 0;
    do begin osc(2'b10, 1'b0); k++; end while (!eo_oe && k < 100);
    chk("R6 next period uses new N", k, 20);

    for (int m = 0; m < 3; m++) begin
      do_reset();
      cfg(2'b10, 3'd0, 16'd50);
      step(1, 0, 0);
      chk("R7 driven before disable", eo_oe, 1);
      halt_i = (m == 0); backup_i = (m == 1); stop_i = (m == 2);
      step(1, 1, 1);
      chk("R7 disable floats output", eo_oe, 0);
      step(1, 1, 1);
      chk("R7 ticks ignored while disabled", eo_oe, 0);
      halt_i = 0; backup_i = 0; stop_i = 0;
      step(1, 0, 0);
      chk("R7 reference restarts after release", eo_oe, 1);
    end

    do_reset();
    lock_lim = 8'd3;
    cfg(2'b10, 3'd0, 16'd2);
    sync_loop(2'b10);
    osc(2'b10, 1'b0);
    osc(2'b10, 1'b0);
    chk("R8 error driven high", eo_oe, 1);
    repeat (3) step(1, 0, 0);
    chk("R8 flag clear at lim ticks", unlock_flag, 0);
    step(1, 0, 0);
    chk("R8 flag set at lim+1 ticks", unlock_flag, 1);
    unlock_clr = 1; step(0, 0, 0); unlock_clr = 0;
    chk("R9 clear strobe drops flag", unlock_flag, 0);
    step(1, 0, 0);
    chk("R9 flag set again", unlock_flag, 1);
    unlock_clr = 1; step(1, 0, 0); unlock_clr = 0;
    chk("R9 set wins over clear", unlock_flag, 1);
    halt_i = 1;
    repeat (3) step(1, 0, 0);
    halt_i = 0;
    chk("R9 flag sticky after error ends", unlock_flag, 1);
    unlock_clr = 1; step(0, 0, 0); unlock_clr = 0;
    chk("R9 clear after sticky", unlock_flag, 0);
    lock_lim = 8'd255;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule